// File: doc/BRIEF.md
# Four-Mode Shift Register

This block holds a word of register state (four bits by default) and, on every rising clock edge, replaces it with one of four computed values picked by a two-bit mode input. The four choices are: invert every bit, rotate one place toward the least significant end, move one place toward the most significant end with a serial bit filling the bottom, and take a parallel word. No mode leaves the register unchanged.

An active-low reset is sampled on the rising edge. While it is low, the register goes to all zeros whatever the mode inputs are. The register drives the output port directly with no logic between, so a new value appears one edge after the inputs that select it.

Top module: `mmshift_top`

## Requirements
- R1: When rst_n is low at a rising clock edge, q becomes all zeros after that edge, whatever mode, sl_in and par_in are.
- R2: With mode = 2'b00, each edge sets q to the bitwise inverse of its previous value, so two edges in a row give back the starting value.
- R3: With mode = 2'b01, each edge moves q one place toward bit 0, and the old bit 0 goes into bit W-1. After W such edges q is back to its starting value.
- R4: With mode = 2'b10, each edge moves q one place toward bit W-1, sl_in goes into bit 0, and the old bit W-1 is dropped.
- R5: With mode = 2'b11, each edge copies par_in into q bit for bit, with bit W-1 as the most significant bit.
- R6: sl_in has no effect on q in any mode except 2'b10. par_in has no effect on q in any mode except 2'b11.
- R7: q changes only at rising clock edges and comes straight from the register bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low, overrides mode |
| mode | input | 2 | 00 invert, 01 rotate toward bit 0, 10 shift toward MSB, 11 load |
| sl_in | input | 1 | Serial bit that enters bit 0 in mode 10 |
| par_in | input | W (4) | Parallel word taken in mode 11 |
| q | output | W (4) | Register contents |

## Verification
A starting value for a rotation or inversion test can only be placed in the register by loading it first. The bench therefore sets each pattern with mode 11, then runs four rotates or two inverts in a row and expects the same pattern back. It drives sl_in and par_in with values that differ from the register bits they would replace while a mode that ignores them is active, so a design that takes them in by mistake changes q. Reset is asserted together with each of the four modes to show that reset takes priority over all of them.

// File: rtl/mmshift_pkg.sv
package mmshift_pkg;
   typedef enum logic [1:0] {
      OP_INV  = 2'b00,
      OP_ROTR = 2'b01,
      OP_SHL  = 2'b10,
      OP_LOAD = 2'b11
   } op_e;
endpackage

// File: rtl/mmshift_next.sv
module mmshift_next
   import mmshift_pkg::*;
#(
   parameter int W = 4
) (
   input  logic [1:0]   mode,
   input  logic         sl_in,
   input  logic [W-1:0] par_in,
   input  logic [W-1:0] cur,
   output logic [W-1:0] nxt
);
   localparam int MSB = W - 1;

   initial begin
      assert (W >= 2) else $error("W must be at least 2");
   end

   logic [W-1:0] rot_v;
   logic [W-1:0] shl_v;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (i == MSB) begin : g_top
            assign rot_v[i] = cur[0];
         end else begin : g_mid
            assign rot_v[i] = cur[i+1];
         end
         if (i == 0) begin : g_low
            assign shl_v[i] = sl_in;
         end else begin : g_up
            assign shl_v[i] = cur[i-1];
         end
      end
   endgenerate

   always_comb begin
      unique case (op_e'(mode))
         OP_INV:  nxt = ~cur;
         OP_ROTR: nxt = rot_v;
         OP_SHL:  nxt = shl_v;
         default: nxt = par_in;
      endcase
   end
endmodule

// File: rtl/mmshift_top.sv
module mmshift_top
   import mmshift_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   mode,
   input  logic         sl_in,
   input  logic [W-1:0] par_in,
   output logic [W-1:0] q
);
   localparam int MSB = W - 1;

   logic [W-1:0] state;
   logic [W-1:0] nxt;
   logic         seen;

   mmshift_next #(.W(W)) u_next (
      .mode  (mode),
      .sl_in (sl_in),
      .par_in(par_in),
      .cur   (state),
      .nxt   (nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) state <= '0;
      else        state <= nxt;
   end

   always_ff @(posedge clk) seen <= 1'b1;

   assign q = state;

   // R1
   rst_clear_chk: assert property (@(posedge clk)
      seen && !rst_n |=> q == '0);
   // R2
   inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen && mode == OP_INV |=> q == ~$past(q));
   // R3
   rotr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen && mode == OP_ROTR |=> q == {$past(q[0]), $past(q[MSB:1])});
   // R4
   shl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen && mode == OP_SHL |=> q == {$past(q[MSB-1:0]), $past(sl_in)});
   // R5
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen && mode == OP_LOAD |=> q == $past(par_in));
endmodule

// File: tb/sim_mmshift_top.sv
module sim_mmshift_top;
   localparam int W = 4;
   logic clk = 0;
   logic rst_n = 0;
   logic [1:0] mode = 0;
   logic sl_in = 0;
   logic [W-1:0] par_in = 0;
   logic [W-1:0] q;
   int checks = 0;
   int errors = 0;
   int ref_q = 0;
   bit done = 0;

   always #2 clk = ~clk;

   mmshift_top #(.W(W)) u0 (.clk(clk), .rst_n(rst_n), .mode(mode),
      .sl_in(sl_in), .par_in(par_in), .q(q));

   task automatic chk(input string req, input int exp);
      checks++;
      if (int'(q) != exp) begin
         errors++;
         $display("FAIL %s q=%0h expected=%0h", req, q, exp);
      end
   endtask

   // drive inputs, one edge, update reference model, check
   task automatic step(input string req, input bit r, input int m, input bit s, input int p);
      rst_n = r; mode = m[1:0]; sl_in = s; par_in = p[W-1:0];
      @(posedge clk);
      if (!r) ref_q = 0;
      else case (m)
         0: ref_q = (~ref_q) & 15;
         1: ref_q = ((ref_q >> 1) | ((ref_q & 1) << 3)) & 15;
         2: ref_q = ((ref_q << 1) | s) & 15;
         default: ref_q = p & 15;
      endcase
      #1;
      chk(req, ref_q);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog q=%0h expected=done", q);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      step("R1", 0, 3, 1, 15);
      step("R1", 0, 0, 1, 15);
      // R5 loads of several patterns
      step("R5", 1, 3, 1, 4'hA);
      step("R5", 1, 3, 0, 4'h3);
      step("R5", 1, 3, 1, 4'h8);
      // R2 repeated invert
      step("R5", 1, 3, 0, 4'h6);
      step("R2", 1, 0, 1, 4'h9);
      if (q != 4'h9) begin end
      step("R2", 1, 0, 1, 4'hF);
      chk("R2 restore", 4'h6);
      // R3 full rotation of several patterns
      for (int pat = 1; pat < 16; pat += 5) begin
         step("R5", 1, 3, 0, pat);
         for (int k = 0; k < 4; k++) step("R3 R6", 1, 1, ~k[0], 4'hF ^ pat);
         chk("R3 full rotation", pat);
      end
      // R4 shift left with mixed serial fill, MSB dropped
      step("R5", 1, 3, 0, 4'hF);
      step("R4", 1, 2, 0, 4'h0);
      step("R4", 1, 2, 1, 4'h0);
      step("R4", 1, 2, 0, 4'hF);
      step("R4", 1, 2, 1, 4'h0);
      chk("R4 pattern", 4'h5);
      // R6 invert ignores sl_in and par_in
      step("R6", 1, 0, 1, 4'h5);
      step("R6", 1, 0, 0, 4'hA);
      // R1 reset beats every mode
      for (int m = 0; m < 4; m++) begin
         step("R5", 1, 3, 0, 4'hD);
         step("R1", 0, m, 1, 4'hE);
      end
      // R7 output stable between edges
      step("R5", 1, 3, 0, 4'hC);
      mode = 0; par_in = 4'h1; sl_in = 1;
      #0.5;
      chk("R7 stable", 4'hC);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule